// File: doc/BRIEF.md
# Divided-Clock Interrupt Countdown Timer

This block is a per-core interrupt timer. Software loads a start value, picks a clock divisor through a 4-bit divide code, and programs one interrupt entry that holds a mask bit, a periodic bit and an 8-bit vector. The timer then counts down at the bus clock divided by the chosen divisor. Each time it runs out it adds one to a pending-expiry count. In periodic mode it reloads and carries on; otherwise it stops.

A pending expiry is offered to the interrupt acceptance logic as a valid flag plus the programmed vector. This happens only while the timer is software-enabled and its entry is unmasked. Every accepted offer takes one off the pending count. The remaining count can be read at any time, expressed in divided ticks. The register bus is not part of this block: each register is written through a one-cycle write strobe with its data.

Top module: `loc_irq_timer`

## Requirements
- R1: The divisor comes from the divide code by forming n = {code[3], code[1], code[0]}; the divisor is 2^((n+1) mod 8). Code bit 2 is ignored. So n = 7 divides by 1 and n = 0 divides by 2.
- R2: A start-value write stops any countdown that is running and clears the pending count. In the cycle after the write, `curCount` equals the written value. An expiry follows after value × divisor clock cycles.
- R3: A start value of zero never expires, and `curCount` then reads 0. Writing zero to a running timer stops it.
- R4: While counting, `curCount` equals floor(remaining clock cycles of the current period / divisor).
- R5: With the periodic bit set, the timer reloads the start value at each expiry. Without it, the timer expires once and `curCount` reads 0 afterwards.
- R6: Each expiry adds one to `pendCount`, which saturates at 255.
- R7: `irqValid` is high only when software enable is set, the entry is unmasked and `pendCount` is nonzero. `irqVector` carries the programmed vector.
- R8: A cycle with `irqValid` and `irqTaken` both high lowers `pendCount` by one.
- R9: Writing software enable as 0 sets the entry mask and clears `pendCount`. An entry write made while disabled leaves the mask set.
- R10: After reset the entry is masked with periodic bit 0, software enable is 0, the divide code is 0 (divide by 2), the start value is 0, and `curCount` and `pendCount` are 0.
- R11: The divide code is sampled again at the start of every period, so a code change made mid-period takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrInit | input | 1 | Write strobe for the start value |
| initData | input | 32 | Start value |
| wrDiv | input | 1 | Write strobe for the divide code |
| divData | input | 4 | Divide code |
| wrEntry | input | 1 | Write strobe for the interrupt entry |
| entryMaskIn | input | 1 | Mask bit to write |
| entryPeriodicIn | input | 1 | Periodic bit to write |
| entryVectorIn | input | 8 | Vector to write |
| wrEnable | input | 1 | Write strobe for software enable |
| enableIn | input | 1 | Software enable value |
| irqTaken | input | 1 | Acceptance logic takes the offered interrupt |
| curCount | output | 32 | Remaining count in divided ticks |
| pendCount | output | 8 | Pending expiries |
| irqValid | output | 1 | Interrupt offered |
| irqVector | output | 8 | Vector of the offered interrupt |
| entryMask | output | 1 | Current mask bit |
| entryPeriodic | output | 1 | Current periodic bit |

## Verification
A start-value write shows its value on `curCount` one clock edge after the strobe. After k further edges `curCount` is floor((N·d − k)/d). The expiry lands in `pendCount` exactly N·d edges after the write edge. Enable, entry and accept strobes change `entryMask`, `irqValid` and `pendCount` at the very next edge. The bench drives every strobe on a falling edge and samples on later falling edges, counting edges since the write. It compares against the formula at every cycle of each period across all sixteen divide codes, and checks the period boundaries of the periodic and resample cases at the exact edge.

// File: rtl/loc_irq_timer_pkg.sv
package loc_irq_timer_pkg;

  // Strobes and levels handed from control to datapath
  typedef struct packed {
    logic start;     // load a new start value and restart
    logic periodic;  // reload at expiry
  } tmrCmd_t;

  // Shift amount of the divisor: {b3,b1,b0} + 1, wrapping modulo 8
  function automatic logic [2:0] divShift(input logic [3:0] code);
    return {code[3], code[1], code[0]} + 3'd1;
  endfunction

endpackage

// File: rtl/loc_irq_timer_dp.sv
module loc_irq_timer_dp
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmd_t          cmd,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [3:0]       divCode,
  output logic             expire,
  output logic [CNT_W-1:0] curCount
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pre;
  logic [2:0]       divSh;
  logic             running;
  logic [CNT_W-1:0] divM1;
  logic             tickEnd;

  assign divM1   = (ONE << divSh) - ONE;
  assign tickEnd = (pre == divM1);
  assign expire  = running && tickEnd && (cnt == ONE);

  // Remaining cycles = cnt*div - pre, reported as whole divided ticks
  assign curCount = (pre == '0) ? cnt : cnt - ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      pre     <= '0;
      divSh   <= 3'd1;
      running <= 1'b0;
    end else if (cmd.start) begin
      cnt     <= loadVal;
      pre     <= '0;
      divSh   <= divShift(divCode);
      running <= (loadVal != '0);
    end else if (running) begin
      if (tickEnd) begin
        pre <= '0;
        if (cnt == ONE) begin
          if (cmd.periodic) begin
            cnt   <= loadVal;
            divSh <= divShift(divCode);
          end else begin
            cnt     <= '0;
            running <= 1'b0;
          end
        end else begin
          cnt <= cnt - ONE;
        end
      end else begin
        pre <= pre + ONE;
      end
    end
  end

  // R2: a restart shows the loaded value on the next cycle
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |=> curCount == $past(loadVal));

  // R5: a one-shot expiry leaves the count at zero
  a_r5_oneshot_zero: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !cmd.periodic && !cmd.start) |=> curCount == '0);

  // R4: between restarts and reloads the count never rises
  a_r4_count_falls: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.start && !expire) |=> curCount <= $past(curCount));

endmodule

// File: rtl/loc_irq_timer_ctrl.sv
module loc_irq_timer_ctrl
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrInit,
  input  logic [CNT_W-1:0]  initData,
  input  logic              wrDiv,
  input  logic [3:0]        divData,
  input  logic              wrEntry,
  input  logic              entryMaskIn,
  input  logic              entryPeriodicIn,
  input  logic [VEC_W-1:0]  entryVectorIn,
  input  logic              wrEnable,
  input  logic              enableIn,
  input  logic              irqTaken,
  input  logic              expire,
  output tmrCmd_t           cmd,
  output logic [CNT_W-1:0]  loadVal,
  output logic [3:0]        divCode,
  output logic [PEND_W-1:0] pendCount,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector,
  output logic              entryMask,
  output logic              entryPeriodic
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [CNT_W-1:0]  initReg;
  logic [3:0]        divReg;
  logic              maskReg;
  logic              perReg;
  logic [VEC_W-1:0]  vecReg;
  logic              softEn;
  logic [PEND_W-1:0] pend;
  logic              disWr;
  logic              accept;

  assign disWr   = wrEnable && !enableIn;
  assign accept  = irqValid && irqTaken;

  assign cmd.start    = wrInit;
  assign cmd.periodic = perReg;
  assign loadVal      = wrInit ? initData : initReg;
  assign divCode      = divReg;

  assign irqValid      = softEn && !maskReg && (pend != '0);
  assign irqVector     = vecReg;
  assign pendCount     = pend;
  assign entryMask     = maskReg;
  assign entryPeriodic = perReg;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initReg <= '0;
      divReg  <= '0;
      maskReg <= 1'b1;
      perReg  <= 1'b0;
      vecReg  <= '0;
      softEn  <= 1'b0;
    end else begin
      if (wrInit) initReg <= initData;
      if (wrDiv)  divReg  <= divData;
      if (wrEntry) begin
        maskReg <= entryMaskIn || !softEn;
        perReg  <= entryPeriodicIn;
        vecReg  <= entryVectorIn;
      end
      if (wrEnable) softEn <= enableIn;
      if (disWr)    maskReg <= 1'b1;
    end
  end

  // Pending-expiry counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
    end else if (wrInit || disWr) begin
      pend <= '0;
    end else begin
      unique case ({expire, accept})
        2'b10:   if (pend != PEND_MAX) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  // R3: no expiry ever comes from a zero start value
  a_r3_zero_quiet: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> initReg != '0);

  // R6: pending count holds at its ceiling
  a_r6_pend_sat: assert property (@(posedge clk) disable iff (!rstN)
    (pend == PEND_MAX && expire && !wrInit && !disWr) |=> pend == PEND_MAX);

  // R8: an accepted offer removes exactly one pending expiry
  a_r8_accept_dec: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !expire && !wrInit && !disWr) |=> pend == $past(pend) - 1'b1);

  // R9: disabling masks the entry and drops everything pending
  a_r9_disable_masks: assert property (@(posedge clk) disable iff (!rstN)
    disWr |=> (maskReg && pend == '0 && !irqValid));

endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer
  import loc_irq_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrInit,
  input  logic [CNT_W-1:0]  initData,
  input  logic              wrDiv,
  input  logic [3:0]        divData,
  input  logic              wrEntry,
  input  logic              entryMaskIn,
  input  logic              entryPeriodicIn,
  input  logic [VEC_W-1:0]  entryVectorIn,
  input  logic              wrEnable,
  input  logic              enableIn,
  input  logic              irqTaken,
  output logic [CNT_W-1:0]  curCount,
  output logic [PEND_W-1:0] pendCount,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector,
  output logic              entryMask,
  output logic              entryPeriodic
);

  tmrCmd_t          cmd;
  logic [CNT_W-1:0] loadVal;
  logic [3:0]       divCode;
  logic             expire;

  loc_irq_timer_ctrl #(.CNT_W(CNT_W), .PEND_W(PEND_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrInit(wrInit), .initData(initData),
    .wrDiv(wrDiv), .divData(divData),
    .wrEntry(wrEntry), .entryMaskIn(entryMaskIn),
    .entryPeriodicIn(entryPeriodicIn), .entryVectorIn(entryVectorIn),
    .wrEnable(wrEnable), .enableIn(enableIn),
    .irqTaken(irqTaken), .expire(expire),
    .cmd(cmd), .loadVal(loadVal), .divCode(divCode),
    .pendCount(pendCount), .irqValid(irqValid), .irqVector(irqVector),
    .entryMask(entryMask), .entryPeriodic(entryPeriodic)
  );

  loc_irq_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cmd(cmd), .loadVal(loadVal), .divCode(divCode),
    .expire(expire), .curCount(curCount)
  );

endmodule

// File: tb/loc_irq_timer_bench.sv
`timescale 1ns/1ps
module loc_irq_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrInit = 1'b0;
  logic [31:0] initData = '0;
  logic        wrDiv = 1'b0;
  logic [3:0]  divData = '0;
  logic        wrEntry = 1'b0;
  logic        entryMaskIn = 1'b1;
  logic        entryPeriodicIn = 1'b0;
  logic [7:0]  entryVectorIn = '0;
  logic        wrEnable = 1'b0;
  logic        enableIn = 1'b0;
  logic        irqTaken = 1'b0;
  logic [31:0] curCount;
  logic [7:0]  pendCount;
  logic        irqValid;
  logic [7:0]  irqVector;
  logic        entryMask;
  logic        entryPeriodic;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  loc_irq_timer u_loc_irq_timer (
    .clk(clk), .rstN(rstN),
    .wrInit(wrInit), .initData(initData),
    .wrDiv(wrDiv), .divData(divData),
    .wrEntry(wrEntry), .entryMaskIn(entryMaskIn),
    .entryPeriodicIn(entryPeriodicIn), .entryVectorIn(entryVectorIn),
    .wrEnable(wrEnable), .enableIn(enableIn),
    .irqTaken(irqTaken),
    .curCount(curCount), .pendCount(pendCount),
    .irqValid(irqValid), .irqVector(irqVector),
    .entryMask(entryMask), .entryPeriodic(entryPeriodic)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All write tasks start and end on a falling edge
  task automatic wInit(input logic [31:0] v);
    wrInit = 1'b1; initData = v;
    @(negedge clk); wrInit = 1'b0;
  endtask
  task automatic wDiv(input logic [3:0] c);
    wrDiv = 1'b1; divData = c;
    @(negedge clk); wrDiv = 1'b0;
  endtask
  task automatic wEntry(input logic m, input logic p, input logic [7:0] v);
    wrEntry = 1'b1; entryMaskIn = m; entryPeriodicIn = p; entryVectorIn = v;
    @(negedge clk); wrEntry = 1'b0;
  endtask
  task automatic wEn(input logic e);
    wrEnable = 1'b1; enableIn = e;
    @(negedge clk); wrEnable = 1'b0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int divOf(input logic [3:0] c);
    logic [2:0] n;
    n = {c[3], c[1], c[0]};
    return 1 << ((int'(n) + 1) % 8);
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 curCount", curCount, 0);
    check("R10 pendCount", pendCount, 0);
    check("R10 irqValid", irqValid, 0);
    check("R10 entryMask", entryMask, 1);
    check("R10 entryPeriodic", entryPeriodic, 0);
    // R10/R1: default divide code gives divide by 2, so start 2 expires after 4 edges
    wInit(2);
    idle(3);
    check("R10 default div no expiry at 3", pendCount, 0);
    @(negedge clk);
    check("R10 default div expiry at 4", pendCount, 1);

    // R1/R4/R5: sweep every divide code, one-shot start value 3
    for (int c = 0; c < 16; c++) begin
      int d, badCur, badPend;
      d = divOf(4'(c));
      badCur = 0; badPend = 0;
      wDiv(4'(c));
      wInit(3);
      for (int k = 0; k <= 3 * d + 2; k++) begin
        int expCur, expPend;
        expCur  = (k < 3 * d) ? (3 * d - k) / d : 0;
        expPend = (k >= 3 * d) ? 1 : 0;
        if (curCount !== 32'(expCur)) badCur++;
        if (pendCount !== 8'(expPend)) badPend++;
        @(negedge clk);
      end
      check($sformatf("R4 R5 countdown code %0d mismatches", c), badCur, 0);
      check($sformatf("R1 expiry cycle code %0d mismatches", c), badPend, 0);
    end

    // R3: zero start stops a running countdown and never expires
    wDiv(4'b1011);
    wInit(1000);
    idle(5);
    wInit(0);
    check("R3 zero count immediately", curCount, 0);
    idle(300);
    check("R3 zero count later", curCount, 0);
    check("R3 no expiry", pendCount, 0);

    // R5: periodic, divide by 1, start 4 -> expiries at 4, 8, 12
    wEntry(1'b1, 1'b1, 8'h00);
    wInit(4);
    idle(11);
    check("R5 periodic before third", pendCount, 2);
    check("R5 periodic count reloaded", curCount, 1);
    @(negedge clk);
    check("R5 periodic third expiry", pendCount, 3);
    check("R5 periodic reload value", curCount, 4);

    // R2: restart clears pending and loads the new value
    wInit(10);
    check("R2 pending cleared", pendCount, 0);
    check("R2 new count", curCount, 10);

    // R6: start 1, divide by 1, periodic -> one expiry per edge, saturates
    wInit(1);
    idle(100);
    check("R6 pending tracks expiries", pendCount, 100);
    idle(200);
    check("R6 pending saturates", pendCount, 255);
    wInit(0);

    // R7/R8: delivery gating and acceptance
    wEn(1'b1);
    wEntry(1'b0, 1'b0, 8'h5A);
    check("R7 entry unmasked when enabled", entryMask, 0);
    wInit(5);
    idle(4);
    check("R7 no offer without pending", irqValid, 0);
    @(negedge clk);
    check("R7 offer after expiry", irqValid, 1);
    check("R7 vector", irqVector, 8'h5A);
    irqTaken = 1'b1;
    @(negedge clk);
    irqTaken = 1'b0;
    check("R8 accepted offer decrements", pendCount, 0);
    check("R8 offer withdrawn", irqValid, 0);
    wInit(1);
    @(negedge clk);
    check("R7 second pending", pendCount, 1);
    wEntry(1'b1, 1'b0, 8'h5A);
    check("R7 masked blocks offer", irqValid, 0);
    irqTaken = 1'b1;
    @(negedge clk);
    irqTaken = 1'b0;
    check("R8 taken while masked has no effect", pendCount, 1);

    // R9: disable masks and clears pending
    wEntry(1'b0, 1'b0, 8'h5A);
    check("R9 offer before disable", irqValid, 1);
    wEn(1'b0);
    check("R9 mask set by disable", entryMask, 1);
    check("R9 pending cleared by disable", pendCount, 0);
    wEntry(1'b0, 1'b1, 8'h33);
    check("R9 entry write while disabled keeps mask", entryMask, 1);

    // R11: divide code resampled at each reload
    wDiv(4'b1011);
    wInit(2);
    wDiv(4'b0001);
    check("R11 first period at old divisor", curCount, 1);
    @(negedge clk);
    check("R11 first expiry", pendCount, 1);
    check("R11 reload count", curCount, 2);
    idle(7);
    check("R11 no second expiry at 9", pendCount, 1);
    @(negedge clk);
    check("R11 second expiry at 10 with divide by 4", pendCount, 2);

    finish_run();
  end

endmodule